// File: doc/BRIEF.md
# Bidirectional Five-Digit Sequencer

This block shows a fixed ring of five decimal digits, one at a time, on a single seven-segment display. Each rising clock edge moves the shown position one place around the ring. The direction level chooses the way: forward runs from the first position to the fifth and then back to the first; backward runs from the first position to the fifth, then the fourth, and so on. The direction may change on any cycle. Each step uses the level present at that clock edge.

The output is a Moore output. It depends only on the current position and never on the direction input. It drives an active-low segment vector directly. The five digits are BCD parameters. A parameter chooses between two output variants: a segment register loaded alongside the position, or a decode read straight from the position. A 3-bit position value that no digit uses returns to the first position on the next edge. Reset is synchronous and active low, so it can come straight from a push key that reads 0 while pressed.

Top module: `digit_ring_seq`

## Requirements
- R1: A clock edge that samples `rst_n` = 0 puts the block at the first digit (parameter nibble SEQ[3:0]). The display then shows that digit's code, whatever `fwd` is.
- R2: Reset is synchronous. Pulling `rst_n` low between edges leaves `seg_n` unchanged until the next rising edge.
- R3: With `fwd` = 1, each edge moves one position forward: nibble k of SEQ is followed by nibble k+1. The step after the fifth position wraps to the first, so the digits 6,0,4,1,2 show 6,0,4,1,2,6 from reset.
- R4: With `fwd` = 0, each edge moves one position backward, and the first position is followed by the fifth. The digits 6,0,4,1,2 show 6,2,1,4,0,6 from reset.
- R5: Direction is sampled at every edge. With the digits 6,0,4,1,2, the per-edge levels 1,1,1,0,0,1,1,1,1 from reset show 6,0,4,1,4,0,4,1,2,6.
- R6: `seg_n` is active low. Bit 0 to bit 6 drive segments a to g, and a 0 lights the segment. The codes are 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000 (written bit 6 down to bit 0).
- R7: Moore output: toggling `fwd` between clock edges does not change `seg_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock; each rising edge is one step |
| rst_n | input | 1 | Synchronous reset, active low |
| fwd | input | 1 | Direction level: 1 forward, 0 backward |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |

## Verification
A wrong position value appears on the segment pins after one edge, because every position has its own display code. The step sequences (a full forward lap, a full backward lap from reset, and a mixed walk that reverses twice) therefore catch a bad increment, decrement or wrap on the cycle it happens. A second instance holds the other five digit values, so every entry of the code table is compared at the pins. Mid-cycle toggles of the direction and reset inputs catch any output that depends on inputs rather than on state, and any reset that acts without a clock edge.

// File: rtl/digit_ring_pkg.sv
package digit_ring_pkg;

   localparam int SEG_W   = 7;
   localparam int BCD_W   = 4;

   typedef logic [SEG_W-1:0] seg_t;
   typedef logic [BCD_W-1:0] bcd_t;

   // Active-low code: bit 0 = a ... bit 6 = g, 0 lights the segment.
   function automatic seg_t seg_of_bcd(input bcd_t d);
      seg_t s;
      case (d)
         4'd0:    s = 7'b1000000;
         4'd1:    s = 7'b1111001;
         4'd2:    s = 7'b0100100;
         4'd3:    s = 7'b0110000;
         4'd4:    s = 7'b0011001;
         4'd5:    s = 7'b0010010;
         4'd6:    s = 7'b0000010;
         4'd7:    s = 7'b1111000;
         4'd8:    s = 7'b0000000;
         4'd9:    s = 7'b0010000;
         default: s = 7'b1111111;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/ring_pos_ctr.sv
module ring_pos_ctr #(
   parameter int NUM_POS = 5,
   parameter int POS_W   = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fwd,
   output logic [POS_W-1:0] pos,
   output logic [POS_W-1:0] pos_nxt
);

   localparam logic [POS_W-1:0] FIRST_POS = '0;
   localparam logic [POS_W-1:0] LAST_POS  = POS_W'(NUM_POS - 1);
   localparam logic [POS_W-1:0] ONE       = POS_W'(1);

   generate
      if (NUM_POS < 2) begin : g_bad_depth
         $error("ring_pos_ctr: NUM_POS must be at least 2");
      end
   endgenerate

   always_comb begin
      if (!rst_n)
         pos_nxt = FIRST_POS;
      else if (pos > LAST_POS)
         pos_nxt = FIRST_POS;
      else if (fwd)
         pos_nxt = (pos == LAST_POS) ? FIRST_POS : pos + ONE;
      else
         pos_nxt = (pos == FIRST_POS) ? LAST_POS : pos - ONE;
   end

   always_ff @(posedge clk)
      pos <= pos_nxt;

   assert_reset_first_R1: assert property (@(posedge clk)
      !rst_n |=> pos == FIRST_POS);

   // Unused encodings recover like a reset (R1).
   assert_bad_pos_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pos > LAST_POS) |=> pos == FIRST_POS);

   assert_fwd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd && pos < LAST_POS) |=> pos == $past(pos) + ONE);

   assert_fwd_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd && pos == LAST_POS) |=> pos == FIRST_POS);

   assert_bwd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd && pos != FIRST_POS && pos <= LAST_POS) |=> pos == $past(pos) - ONE);

   assert_bwd_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd && pos == FIRST_POS) |=> pos == LAST_POS);

endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
   import digit_ring_pkg::*;
#(
   parameter int              NUM_POS = 5,
   parameter int              POS_W   = 3,
   parameter logic [NUM_POS*BCD_W-1:0] SEQ = '0,
   parameter bit              REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic [POS_W-1:0] pos,
   input  logic [POS_W-1:0] pos_nxt,
   output seg_t             seg_n
);

   localparam seg_t BLANK = '1;

   seg_t code_tbl [NUM_POS];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_POS; gi++) begin : g_code
         if (SEQ[gi*BCD_W +: BCD_W] > 4'd9) begin : g_bad_digit
            $error("seg_out_stage: digit parameter is not BCD");
         end
         assign code_tbl[gi] = seg_of_bcd(SEQ[gi*BCD_W +: BCD_W]);
      end
   endgenerate

   function automatic seg_t pick(input logic [POS_W-1:0] p);
      seg_t s = BLANK;
      for (int k = 0; k < NUM_POS; k++)
         if (p == POS_W'(k)) s = code_tbl[k];
      return s;
   endfunction

   generate
      if (REG_OUT) begin : g_reg
         seg_t seg_q;
         always_ff @(posedge clk)
            seg_q <= pick(pos_nxt);
         assign seg_n = seg_q;
      end else begin : g_comb
         assign seg_n = pick(pos);
      end
   endgenerate

endmodule

// File: rtl/digit_ring_seq.sv
module digit_ring_seq
   import digit_ring_pkg::*;
#(
   parameter int NUM_POS = 5,
   parameter logic [NUM_POS*BCD_W-1:0] SEQ = {4'd2, 4'd1, 4'd4, 4'd0, 4'd6},
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fwd,
   output logic [SEG_W-1:0] seg_n
);

   localparam int POS_W = (NUM_POS > 1) ? $clog2(NUM_POS) : 1;

   logic [POS_W-1:0] pos;
   logic [POS_W-1:0] pos_nxt;

   ring_pos_ctr #(
      .NUM_POS (NUM_POS),
      .POS_W   (POS_W)
   ) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .fwd     (fwd),
      .pos     (pos),
      .pos_nxt (pos_nxt)
   );

   seg_out_stage #(
      .NUM_POS (NUM_POS),
      .POS_W   (POS_W),
      .SEQ     (SEQ),
      .REG_OUT (REG_OUT)
   ) u_seg (
      .clk     (clk),
      .pos     (pos),
      .pos_nxt (pos_nxt),
      .seg_n   (seg_n)
   );

   // Moore: the display moves only when the position moves (R7).
   assert_moore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(pos) |-> $stable(seg_n));

   // After reset the display shows the first digit's code (R1, R6).
   assert_reset_code_R1: assert property (@(posedge clk)
      !rst_n |=> seg_n == seg_of_bcd(SEQ[BCD_W-1:0]));

endmodule

// File: tb/digit_ring_seq_bench.sv
module digit_ring_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fwd = 1'b1;
   logic [6:0] seg_a;
   logic [6:0] seg_b;

   int checks = 0;
   int failures = 0;
   int p = 0;           // expected position, model of R3/R4

   localparam int DIG_A [5] = '{6, 0, 4, 1, 2};
   localparam int DIG_B [5] = '{3, 5, 7, 8, 9};

   // {fwd, expected position after the edge}: mixed walk for R5
   localparam int NVEC = 9;
   localparam logic [3:0] VEC [NVEC] = '{
      {1'b1, 3'd1}, {1'b1, 3'd2}, {1'b1, 3'd3}, {1'b0, 3'd2}, {1'b0, 3'd1},
      {1'b1, 3'd2}, {1'b1, 3'd3}, {1'b1, 3'd4}, {1'b1, 3'd0}};

   always #4 clk = ~clk;   // 125 MHz

   digit_ring_seq u_digit_ring_seq (
      .clk(clk), .rst_n(rst_n), .fwd(fwd), .seg_n(seg_a));

   digit_ring_seq #(
      .SEQ({4'd9, 4'd8, 4'd7, 4'd5, 4'd3}), .REG_OUT(1'b0)
   ) u_alt (
      .clk(clk), .rst_n(rst_n), .fwd(fwd), .seg_n(seg_b));

   function automatic logic [6:0] code_of(input int d);
      case (d)
         0: return 7'b1000000;  1: return 7'b1111001;
         2: return 7'b0100100;  3: return 7'b0110000;
         4: return 7'b0011001;  5: return 7'b0010010;
         6: return 7'b0000010;  7: return 7'b1111000;
         8: return 7'b0000000;  9: return 7'b0010000;
         default: return 7'b1111111;
      endcase
   endfunction

   task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%b exp=%b", req, got, exp);
      end
   endtask

   task automatic check_pos(input string req);
      check(req, seg_a, code_of(DIG_A[p]));
      check(req, seg_b, code_of(DIG_B[p]));
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input logic dir);
      fwd = dir;
      @(posedge clk);
      @(negedge clk);
      if (dir) p = (p == 4) ? 0 : p + 1;
      else     p = (p == 0) ? 4 : p - 1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      p = 0;
   endtask

   initial begin
      #(8 * 5000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_pos("R1 reset shows first digit");

      // R5: table-driven mixed walk
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][3]);
         if (p != int'(VEC[i][2:0])) begin
            failures++;
            $display("FAIL R5 model pos=%0d exp=%0d", p, VEC[i][2:0]);
         end
         check_pos("R5 mixed direction walk");
      end

      // R3: forward lap with wrap, R6 codes on both instances
      do_reset();
      for (int i = 0; i < 6; i++) begin
         step(1'b1);
         check_pos("R3 forward lap / R6 codes");
      end

      // R4: backward lap from reset
      do_reset();
      for (int i = 0; i < 6; i++) begin
         step(1'b0);
         check_pos("R4 backward lap / R6 codes");
      end

      // R7: toggle direction between edges, display must hold
      step(1'b1);
      fwd = 1'b0; #1;
      check("R7 fwd toggle low", seg_a, code_of(DIG_A[p]));
      check("R7 fwd toggle low alt", seg_b, code_of(DIG_B[p]));
      fwd = 1'b1; #1;
      check("R7 fwd toggle high", seg_a, code_of(DIG_A[p]));
      check("R7 fwd toggle high alt", seg_b, code_of(DIG_B[p]));

      // R2: reset between edges waits for the edge; R1 ignores fwd
      step(1'b1);
      rst_n = 1'b0; fwd = 1'b0; #1;
      check("R2 reset before edge", seg_a, code_of(DIG_A[p]));
      check("R2 reset before edge alt", seg_b, code_of(DIG_B[p]));
      @(posedge clk);
      @(negedge clk);
      p = 0;
      check_pos("R1 reset at edge with fwd=0");
      rst_n = 1'b1;

      // R1: reset held several edges with fwd=1 stays at first digit
      rst_n = 1'b0; fwd = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_pos("R1 reset held");
      rst_n = 1'b1;
      step(1'b0);
      check_pos("R4 first step back after reset");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule